// File: doc/BRIEF.md
# Cascadable Dual Timer/Counter Pair

Two 16-bit timer/counter channels, A and B, sit behind a small register bus. Each channel has a control register, a command register that can only be written, a reload register and a count register that returns the live value. A channel counts one of two things. In timer mode it counts strobes from a prescaler outside the block. In event mode it counts chosen edges of an input, and that input can be inverted and synchronised first. Each channel counts up or down. When its count passes its end value it expires: the reload value is copied into the count, and the channel either carries on or stops, as its one-shot bit selects. Each expiry sets a pending flag for that channel, and a flag that is enabled drives the interrupt output.

A wide-mode bit that exists only in channel A's control register joins the two channels into a single 32-bit counter. Channel A then holds the low half and channel B the high half, for both the count and the reload value. Channel A's configuration and commands control the whole 32-bit counter, and only channel A can raise an expiry. Software sets a reload value, starts the channel with a load command, and then either polls the count or services the interrupt.

Top module: `timer_pair`

## Requirements
- R1: Control register field positions: bit 1 up (1 = count up), bit 2 event mode, bit 3 one-shot, bit 4 wide (channel A only), bit 5 invert, bits 7:6 edge code, bit 8 synchronise, bit 9 gate, bit 10 tick source. Bit 0 reads 1 while the channel runs and ignores writes. Bit 4 of channel B always reads 0.
- R2: In timer mode (bit 2 = 0), a running channel takes one step on each cycle where `tick_i` is high. If bit 9 is set, a step also requires the conditioned input level to be high.
- R3: Counting down, a step from 0 is an expiry. Counting up, a step from all ones is an expiry. On any other step the count moves by one. On an expiry the count takes the reload value.
- R4: With bit 3 set, the channel stops after its first expiry and control bit 0 reads 0. With bit 3 clear, it keeps running.
- R5: In event mode (bit 2 = 1), a step happens on the edges selected by bits 7:6: 00 none, 01 rising, 10 falling, 11 both. An edge is found by comparing the conditioned level with its value in the previous cycle. Bit 10 set takes `tick_i` as the source in place of the channel's pin.
- R6: Bit 5 inverts the source level. Bit 8 passes the source through two flip-flops before edge detection, which delays every step by two cycles.
- R7: In the command register, bit 0 starts the channel and bit 1 stops it; stop wins if both are set. Bit 2 copies the reload value into the count, and this load overrides that cycle's step. A start without bit 2 resumes from the held count. A channel that is stopped holds its count.
- R8: When channel A's bit 4 is set, the count is {B, A} and the reload is {reload B, reload A}, both 32 bits. Channel A's configuration and commands drive the counter, writes to channel B's command register have no effect, and channel B never expires.
- R9: Pending bit 0 belongs to A and bit 1 to B, and an expiry sets it. Writing a 1 to a bit at address 9 clears it, but an expiry in the same cycle wins. `irq_o` is the OR of pending AND enable, where enable is register 8.
- R10: Address map: 0/1 control A/B, 2/3 command A/B (reads 0), 4/5 reload A/B, 6/7 count A/B, 8 interrupt enable, 9 pending (write 1 to clear). Every register reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_i | input | 1 | Prescaled tick strobe |
| ext_i | input | 2 | External inputs; bit 0 for channel A, bit 1 for channel B |
| irq_o | output | 1 | Interrupt, OR of enabled pending flags |

## Verification
A wrong count, run status or pending flag appears on `bus_rdata` in the cycle right after the faulty update, because the count register is read combinationally from the state the bench is watching. Errors in the synchroniser or in edge detection do not show at once: the count is off by one step only after the next selected edge. That is two cycles late when synchronise is on. An error in the wide-mode carry between the halves shows only when the low half wraps, so the bench places 32-bit reload values close to that boundary. A fault in a pending flag reaches `irq_o` one cycle after the expiry that should, or should not, have set it.

// File: rtl/timer_pair_pkg.sv
package timer_pair_pkg;

    localparam int CTRL_W    = 11;
    localparam int RUN_GO    = 0;
    localparam int RUN_STOP  = 1;
    localparam int RUN_LOAD  = 2;

    localparam int ADR_CTRL_A = 0;
    localparam int ADR_CTRL_B = 1;
    localparam int ADR_RUN_A  = 2;
    localparam int ADR_RUN_B  = 3;
    localparam int ADR_RLD_A  = 4;
    localparam int ADR_RLD_B  = 5;
    localparam int ADR_CNT_A  = 6;
    localparam int ADR_CNT_B  = 7;
    localparam int ADR_IEN    = 8;
    localparam int ADR_IPEND  = 9;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    // Packed so that the struct lines up with control bits 10:1.
    typedef struct packed {
        logic      tick_src;  // bit 10
        logic      gate;      // bit 9
        logic      sync;      // bit 8
        edge_sel_e edge_sel;  // bits 7:6
        logic      inv;       // bit 5
        logic      wide;      // bit 4
        logic      once;      // bit 3
        logic      evt_mode;  // bit 2
        logic      up;        // bit 1
    } chan_cfg_t;

endpackage

// File: rtl/tp_input_cond.sv
module tp_input_cond
    import timer_pair_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_i,
    input  logic      tick_i,
    input  chan_cfg_t cfg_i,
    output logic      event_o
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } cond_t;

    cond_t cond_d, cond_q;
    logic  src, lvl, rise, fall, hit;
    logic  unused_cfg;

    assign unused_cfg = ^{cfg_i.up, cfg_i.once, cfg_i.wide};

    always_comb begin
        src  = (cfg_i.evt_mode && cfg_i.tick_src) ? tick_i : pin_i;
        lvl  = (cfg_i.sync ? cond_q.s2 : src) ^ cfg_i.inv;
        rise = lvl & ~cond_q.prev;
        fall = ~lvl & cond_q.prev;
        case (cfg_i.edge_sel)
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            EDGE_BOTH: hit = rise | fall;
            default:   hit = 1'b0;
        endcase
        event_o     = cfg_i.evt_mode ? hit : (tick_i & (~cfg_i.gate | lvl));
        cond_d.s1   = src;
        cond_d.s2   = cond_q.s1;
        cond_d.prev = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cond_q <= '0;
        else        cond_q <= cond_d;
    end

endmodule

// File: rtl/tp_irq_flags.sv
module tp_irq_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         en_we_i,
    input  logic         clr_we_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] en_o,
    output logic [N-1:0] pend_o,
    output logic         irq_o
);

    typedef struct packed {
        logic [N-1:0] en;
        logic [N-1:0] pend;
    } irq_t;

    irq_t irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (en_we_i)  irq_d.en   = wdata_i;
        if (clr_we_i) irq_d.pend = irq_q.pend & ~wdata_i;
        irq_d.pend = irq_d.pend | set_i;   // an expiry outranks a clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign en_o   = irq_q.en;
    assign pend_o = irq_q.pend;
    assign irq_o  = |(irq_q.pend & irq_q.en);

    for (genvar i = 0; i < N; i++) begin : g_chk
        p_pend_origin_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_q.pend[i]) |-> $past(set_i[i]));
        p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we_i && wdata_i[i] && !set_i[i]) |=> !irq_q.pend[i]);
    end

endmodule

// File: rtl/timer_pair.sv
module timer_pair
    import timer_pair_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int AW     = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [AW-1:0]       bus_addr,
    input  logic [2*HALF_W-1:0] bus_wdata,
    output logic [2*HALF_W-1:0] bus_rdata,
    input  logic                tick_i,
    input  logic [1:0]          ext_i,
    output logic                irq_o
);

    localparam int FULL_W = 2 * HALF_W;
    localparam int DW     = FULL_W;
    localparam int NCH    = 2;

    typedef struct packed {
        chan_cfg_t [NCH-1:0]             cfg;
        logic      [NCH-1:0]             run;
        logic      [NCH-1:0][HALF_W-1:0] rld;
        logic      [NCH-1:0][HALF_W-1:0] cnt;
    } core_t;

    core_t              st_d, st_q;
    logic [NCH-1:0]     chan_ev;
    logic [NCH-1:0]     expire;
    logic [FULL_W:0]    res;
    logic [NCH-1:0]     ien, ipend;
    logic               ien_we, iclr_we;
    logic               unused_wdata;

    assign unused_wdata = ^bus_wdata[DW-1:HALF_W];

    // {expiry, next value}; wide selects the 32-bit end value
    function automatic logic [FULL_W:0] step_val(input logic [FULL_W-1:0] cur,
                                                 input logic [FULL_W-1:0] rld,
                                                 input logic up,
                                                 input logic wide);
        logic [FULL_W-1:0] top;
        top = wide ? {FULL_W{1'b1}} : FULL_W'({HALF_W{1'b1}});
        if (up) return (cur == top)   ? {1'b1, rld} : {1'b0, cur + 1'b1};
        else    return (cur == '0)    ? {1'b1, rld} : {1'b0, cur - 1'b1};
    endfunction

    for (genvar g = 0; g < NCH; g++) begin : g_cond
        tp_input_cond u_cond (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (ext_i[g]),
            .tick_i  (tick_i),
            .cfg_i   (st_q.cfg[g]),
            .event_o (chan_ev[g])
        );
    end

    always_comb begin
        st_d   = st_q;
        expire = '0;
        res    = '0;
        // counting step
        if (st_q.cfg[0].wide) begin
            if (st_q.run[0] && chan_ev[0]) begin
                res = step_val({st_q.cnt[1], st_q.cnt[0]}, {st_q.rld[1], st_q.rld[0]},
                               st_q.cfg[0].up, 1'b1);
                {st_d.cnt[1], st_d.cnt[0]} = res[FULL_W-1:0];
                expire[0] = res[FULL_W];
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (st_q.run[c] && chan_ev[c]) begin
                    res = step_val(FULL_W'(st_q.cnt[c]), FULL_W'(st_q.rld[c]),
                                   st_q.cfg[c].up, 1'b0);
                    st_d.cnt[c] = res[HALF_W-1:0];
                    expire[c]   = res[FULL_W];
                end
            end
        end
        for (int c = 0; c < NCH; c++) begin
            if (expire[c] && st_q.cfg[c].once) st_d.run[c] = 1'b0;
        end
        // register writes take effect after the step
        if (bus_we) begin
            case (bus_addr)
                AW'(ADR_CTRL_A): st_d.cfg[0] = chan_cfg_t'(bus_wdata[CTRL_W-1:1]);
                AW'(ADR_CTRL_B): begin
                    st_d.cfg[1]      = chan_cfg_t'(bus_wdata[CTRL_W-1:1]);
                    st_d.cfg[1].wide = 1'b0;
                end
                AW'(ADR_RUN_A): begin
                    if (bus_wdata[RUN_LOAD]) begin
                        st_d.cnt[0] = st_q.rld[0];
                        if (st_q.cfg[0].wide) st_d.cnt[1] = st_q.rld[1];
                    end
                    if (bus_wdata[RUN_STOP])    st_d.run[0] = 1'b0;
                    else if (bus_wdata[RUN_GO]) st_d.run[0] = 1'b1;
                end
                AW'(ADR_RUN_B): begin
                    if (!st_q.cfg[0].wide) begin
                        if (bus_wdata[RUN_LOAD])    st_d.cnt[1] = st_q.rld[1];
                        if (bus_wdata[RUN_STOP])    st_d.run[1] = 1'b0;
                        else if (bus_wdata[RUN_GO]) st_d.run[1] = 1'b1;
                    end
                end
                AW'(ADR_RLD_A): st_d.rld[0] = bus_wdata[HALF_W-1:0];
                AW'(ADR_RLD_B): st_d.rld[1] = bus_wdata[HALF_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ien_we  = bus_we && (bus_addr == AW'(ADR_IEN));
    assign iclr_we = bus_we && (bus_addr == AW'(ADR_IPEND));

    tp_irq_flags #(.N(NCH)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (expire),
        .en_we_i  (ien_we),
        .clr_we_i (iclr_we),
        .wdata_i  (bus_wdata[NCH-1:0]),
        .en_o     (ien),
        .pend_o   (ipend),
        .irq_o    (irq_o)
    );

    always_comb begin
        case (bus_addr)
            AW'(ADR_CTRL_A): bus_rdata = DW'({st_q.cfg[0], st_q.run[0]});
            AW'(ADR_CTRL_B): bus_rdata = DW'({st_q.cfg[1], st_q.run[1]});
            AW'(ADR_RLD_A):  bus_rdata = DW'(st_q.rld[0]);
            AW'(ADR_RLD_B):  bus_rdata = DW'(st_q.rld[1]);
            AW'(ADR_CNT_A):  bus_rdata = DW'(st_q.cnt[0]);
            AW'(ADR_CNT_B):  bus_rdata = DW'(st_q.cnt[1]);
            AW'(ADR_IEN):    bus_rdata = DW'(ien);
            AW'(ADR_IPEND):  bus_rdata = DW'(ipend);
            default:         bus_rdata = '0;
        endcase
    end

    p_once_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run[0] && expire[0] && st_q.cfg[0].once && !bus_we) |=> !st_q.run[0]);

    p_wide_b_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cfg[0].wide |-> !expire[1]);

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run[0] && !bus_we) |=> $stable(st_q.cnt[0]));

endmodule

// File: tb/timer_pair_tb.sv
module timer_pair_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_i = 1'b0;
    logic [1:0]  ext_i = '0;
    logic        irq_o;

    always #5 clk = ~clk;

    timer_pair u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_i(tick_i),
        .ext_i(ext_i), .irq_o(irq_o)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    int    phase = 0;
    int    tick_per = 0;
    int    pin_per [2] = '{0, 0};
    int    mon = 6;
    string cur_tag = "R10";

    // behavioural reference state
    logic [10:0] m_cfg [2];
    logic        m_run [2];
    logic [15:0] m_rld [2];
    logic [15:0] m_cnt [2];
    logic [1:0]  m_en, m_pend;
    logic        m_s1 [2], m_s2 [2], m_prev [2];

    // stimulus generators
    always @(negedge clk) begin
        phase++;
        tick_i <= (tick_per == 0) ? 1'b0 : (phase % tick_per == 0);
        for (int c = 0; c < 2; c++)
            if (pin_per[c] > 0 && phase % pin_per[c] == 0) ext_i[c] <= ~ext_i[c];
    end

    always @(posedge clk) begin : model
        logic [1:0]  ev, ex;
        logic        src, lvl, hit;
        logic [31:0] v;
        logic [15:0] w;
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_cfg[c] = '0; m_run[c] = 0; m_rld[c] = '0; m_cnt[c] = '0;
                m_s1[c] = 0; m_s2[c] = 0; m_prev[c] = 0;
            end
            m_en = '0; m_pend = '0;
        end else begin
            for (int c = 0; c < 2; c++) begin
                src = (m_cfg[c][2] && m_cfg[c][10]) ? tick_i : ext_i[c];
                lvl = (m_cfg[c][8] ? m_s2[c] : src) ^ m_cfg[c][5];
                case (m_cfg[c][7:6])
                    2'b01:   hit = lvl && !m_prev[c];
                    2'b10:   hit = !lvl && m_prev[c];
                    2'b11:   hit = lvl != m_prev[c];
                    default: hit = 1'b0;
                endcase
                ev[c] = m_cfg[c][2] ? hit : (tick_i && (!m_cfg[c][9] || lvl));
                m_s2[c] = m_s1[c]; m_s1[c] = src; m_prev[c] = lvl;
            end
            ex = '0;
            if (m_cfg[0][4]) begin
                if (m_run[0] && ev[0]) begin
                    v = {m_cnt[1], m_cnt[0]};
                    if (m_cfg[0][1]) begin
                        if (v == 32'hFFFF_FFFF) begin ex[0] = 1; v = {m_rld[1], m_rld[0]}; end
                        else v = v + 32'd1;
                    end else begin
                        if (v == 32'd0) begin ex[0] = 1; v = {m_rld[1], m_rld[0]}; end
                        else v = v - 32'd1;
                    end
                    m_cnt[1] = v[31:16]; m_cnt[0] = v[15:0];
                end
            end else begin
                for (int c = 0; c < 2; c++) if (m_run[c] && ev[c]) begin
                    w = m_cnt[c];
                    if (m_cfg[c][1]) begin
                        if (w == 16'hFFFF) begin ex[c] = 1; w = m_rld[c]; end else w = w + 16'd1;
                    end else begin
                        if (w == 16'd0) begin ex[c] = 1; w = m_rld[c]; end else w = w - 16'd1;
                    end
                    m_cnt[c] = w;
                end
            end
            for (int c = 0; c < 2; c++) if (ex[c] && m_cfg[c][3]) m_run[c] = 0;
            if (bus_we) begin
                case (bus_addr)
                    4'd0: m_cfg[0] = bus_wdata[10:0] & 11'h7FE;
                    4'd1: m_cfg[1] = bus_wdata[10:0] & 11'h7EE;
                    4'd2: begin
                        if (bus_wdata[2]) begin
                            m_cnt[0] = m_rld[0];
                            if (m_cfg[0][4]) m_cnt[1] = m_rld[1];
                        end
                        if (bus_wdata[1]) m_run[0] = 0; else if (bus_wdata[0]) m_run[0] = 1;
                    end
                    4'd3: if (!m_cfg[0][4]) begin
                        if (bus_wdata[2]) m_cnt[1] = m_rld[1];
                        if (bus_wdata[1]) m_run[1] = 0; else if (bus_wdata[0]) m_run[1] = 1;
                    end
                    4'd4: m_rld[0] = bus_wdata[15:0];
                    4'd5: m_rld[1] = bus_wdata[15:0];
                    4'd8: m_en = bus_wdata[1:0];
                    4'd9: m_pend = m_pend & ~bus_wdata[1:0];
                    default: ;
                endcase
            end
            m_pend = m_pend | ex;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [3:0] a);
        case (a)
            4'd0: return 32'(m_cfg[0] | 11'(m_run[0]));
            4'd1: return 32'(m_cfg[1] | 11'(m_run[1]));
            4'd4: return 32'(m_rld[0]);
            4'd5: return 32'(m_rld[1]);
            4'd6: return 32'(m_cnt[0]);
            4'd7: return 32'(m_cnt[1]);
            4'd8: return 32'(m_en);
            4'd9: return 32'(m_pend);
            default: return 32'd0;
        endcase
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // per-cycle comparison, away from the clock edge
    always @(posedge clk) begin
        logic [31:0] e;
        logic        ei;
        #2;
        e  = exp_rd(bus_addr);
        ei = |(m_pend & m_en);
        n_cmp++;
        if (bus_rdata !== e || irq_o !== ei) begin
            n_bad++;
            $display("FAIL %s addr=%0d rdata=%h expected %h irq=%b expected %b",
                     cur_tag, bus_addr, bus_rdata, e, irq_o, ei);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_bad++;
            $display("FAIL R10 watchdog: cycles %0d expected below %0d", cyc, 50000);
            summary();
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 4'(a); bus_wdata = 32'(d);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 4'(mon);
    endtask

    task automatic watch(input int a, input int n, input string tag);
        @(negedge clk);
        mon = a; cur_tag = tag; bus_addr = 4'(a);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset values of every address
        for (int a = 0; a < 10; a++) watch(a, 2, "R10");

        // R2 / R3: timer mode down count, cyclic, tick every third cycle
        cur_tag = "R2";
        wr(4, 3); wr(8, 1); wr(0, 'h000);
        tick_per = 3;
        wr(2, 5);
        watch(6, 30, "R3");
        watch(9, 4, "R9");
        wr(9, 1);
        watch(9, 6, "R9");
        // R2: gated timer, pin A toggles every 4 cycles, ticks every cycle
        tick_per = 1; pin_per[0] = 4;
        wr(0, 'h200);
        watch(6, 24, "R2");

        // R4: one-shot up count close to all ones
        pin_per[0] = 0;
        wr(4, 'hFFFC); wr(0, 'h00A); wr(2, 5);
        watch(0, 10, "R4");
        watch(6, 4, "R4");
        if (bus_rdata !== 32'hFFFC) begin
            n_bad++;
            $display("FAIL R4 held count=%h expected %h", bus_rdata, 32'hFFFC);
        end
        n_cmp++;

        // R7: run commands
        wr(4, 10); wr(0, 'h000); wr(2, 5);
        watch(6, 5, "R7");
        wr(2, 2); watch(6, 6, "R7");
        wr(2, 1); watch(6, 4, "R7");
        wr(2, 3); watch(0, 4, "R7");
        wr(2, 4); watch(6, 4, "R7");
        wr(2, 2);

        // R5: event mode on channel B, every edge code, pin B toggles every 2 cycles
        tick_per = 0; pin_per[1] = 2;
        wr(5, 100); wr(8, 3);
        for (int code = 0; code < 4; code++) begin
            wr(1, 'h006 | (code << 6));
            wr(3, 5);
            watch(7, 16, "R5");
        end
        // R5: tick strobe as source
        tick_per = 2;
        wr(1, 'h4C6); wr(3, 5);
        watch(7, 12, "R5");
        // R6: inversion and synchroniser
        tick_per = 0; pin_per[1] = 5;
        wr(1, 'h164); wr(3, 5);
        watch(7, 20, "R6");
        wr(1, 'h0A4);
        watch(7, 20, "R6");
        // R5: down count through zero in event mode
        wr(5, 2); wr(1, 'h0C4); wr(3, 5);
        watch(7, 16, "R5");
        watch(9, 2, "R9");
        wr(9, 3);
        wr(3, 2);

        // R8: wide mode, 0x0001_0000 counts down across the half boundary
        pin_per[1] = 0; tick_per = 1;
        wr(4, 0); wr(5, 1); wr(0, 'h010); wr(2, 5);
        watch(6, 3, "R8");
        watch(7, 3, "R8");
        wr(4, 2); wr(5, 0); wr(2, 5);
        watch(6, 8, "R8");
        watch(9, 2, "R8");
        wr(3, 2);
        watch(0, 3, "R8");
        wr(4, 'hFFFE); wr(5, 'hFFFF); wr(0, 'h012); wr(2, 5);
        watch(6, 4, "R8");
        watch(7, 4, "R8");
        wr(2, 2);

        // R1: control readback, B cannot hold the wide bit
        wr(1, 'h7FF);
        watch(1, 3, "R1");
        wr(0, 'h7FF);
        watch(0, 3, "R1");
        wr(2, 2); wr(0, 0);

        // R9: enable masking and clear
        wr(8, 0); watch(9, 3, "R9");
        wr(8, 2); watch(9, 3, "R9");
        wr(9, 3); watch(9, 3, "R9");

        summary();
    end

endmodule